// File: doc/BRIEF.md
# Upper-Memory Shadow Routing Decoder

This block is the configuration and routing unit for the upper 256 KB of the first megabyte of CPU memory space. Software reaches it through two I/O ports. A write to the index port picks one of sixteen 8-bit configuration registers. A write to the data port stores a value into the selected register, and a read from the data port returns that register's value.

Three of the registers hold read-enable and write-enable bit pairs. Each pair covers one region: a 16 KB segment of C0000–DFFFF, or the whole 64 KB at E0000 or at F0000.

For every CPU memory access, the block takes the 20-bit address and a write flag and returns a 2-bit route code:
- internal shadow DRAM;
- the external bus;
- discard, for a write into a region shadowed as read-only.

Addresses below C0000 are outside its window and always route to internal memory. The decode is combinational from the register state, so a new setting applies to the first access decoded after the data-port write's clock edge.

Top module: `shd_route`

## Requirements
- R1: After reset all registers and the index are zero, and every access in C0000–FFFFF, read or write, gets route code 1 (external bus).
- R2: A write strobe with `io_addr` equal to 0x24 stores `io_wdata` into the register selected by the index at the next clock edge. A read strobe at 0x24 returns the selected register on `io_rdata` in the same cycle. `io_rdata` is zero whenever no data-port read is strobed.
- R3: A write strobe at I/O address 0x22 loads the index from the low 4 bits of `io_wdata`; the upper bits are ignored (index 0x15 selects register 5).
- R4: Register 4 governs C0000–CFFFF and register 5 governs D0000–DFFFF. Segment n (n = address bits 15:14) uses bit 2n as read enable and bit 2n+1 as write enable.
- R5: Register 6 governs the 64 KB regions. Bits 0/1 are read/write enable for E0000–EFFFF, and bits 2/3 are read/write enable for F0000–FFFFF.
- R6: A read (`mem_we`=0) inside the window gets code 0 (internal) when its region's read enable is set, and code 1 (external) otherwise. A read never gets code 2.
- R7: A write inside the window gets code 0 when the write enable is set. It gets code 2 (discard) when only the read enable is set, and code 1 when both enables are clear.
- R8: Any access with address bits 19:18 not equal to 2'b11 (below C0000) gets code 0.
- R9: A data-port write changes the route of an access held stable only after the clock edge that stores it, and from that edge on.
- R10: The route code is never 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| io_wr | input | 1 | I/O write strobe |
| io_rd | input | 1 | I/O read strobe |
| io_addr | input | 16 | I/O port address |
| io_wdata | input | 8 | I/O write data |
| io_rdata | output | 8 | I/O read data (same cycle) |
| mem_addr | input | 20 | CPU memory address |
| mem_we | input | 1 | 1 = write access, 0 = read access |
| mem_route | output | 2 | 0 internal, 1 external, 2 discard |

## Verification
The state inside the block is the index and the register file. A wrong index or a lost data write shows up in two places: on `io_rdata` in the cycle of the next data-port read, and on `mem_route` for the next access into the affected segment. A bit-field mapping error appears only for the segment whose pair is mis-decoded. For that reason the vector walk programs every segment with a distinct enable pattern and probes both segment edges under reads and writes. A late or early register update is caught by probing the route on both sides of the storing clock edge.

// File: rtl/shd_pkg.sv
package shd_pkg;

   typedef enum logic [1:0] {
      ROUTE_INT  = 2'd0,
      ROUTE_EXT  = 2'd1,
      ROUTE_DROP = 2'd2
   } route_e;

   // Route for one access given the region's enable pair.
   function automatic route_e route_of(input logic rd_en,
                                       input logic wr_en,
                                       input logic is_wr);
      route_e r;
      if (!is_wr)     r = rd_en ? ROUTE_INT : ROUTE_EXT;
      else if (wr_en) r = ROUTE_INT;
      else if (rd_en) r = ROUTE_DROP;
      else            r = ROUTE_EXT;
      return r;
   endfunction

endpackage

// File: rtl/shd_regfile.sv
module shd_regfile #(
   parameter int IO_AW = 16,
   parameter int DW = 8,
   parameter int NREG = 16,
   parameter logic [IO_AW-1:0] IDX_PORT = 16'h0022,
   parameter logic [IO_AW-1:0] DATA_PORT = 16'h0024,
   localparam int IW = $clog2(NREG)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 io_wr,
   input  logic                 io_rd,
   input  logic [IO_AW-1:0]     io_addr,
   input  logic [DW-1:0]        io_wdata,
   output logic [DW-1:0]        io_rdata,
   output logic [IW-1:0]        idx_q,
   output logic [NREG*DW-1:0]   regs_flat
);

   if ((1 << IW) != NREG) begin : g_bad_nreg
      $error("shd_regfile: NREG must be a power of two");
   end
   if (DW < IW) begin : g_bad_dw
      $error("shd_regfile: DW too narrow to carry an index");
   end

   logic hit_idx, hit_dat;
   logic [DW-1:0] regs_q [NREG];

   assign hit_idx = (io_addr == IDX_PORT);
   assign hit_dat = (io_addr == DATA_PORT);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         idx_q <= '0;
      end else if (io_wr && hit_idx) begin
         idx_q <= io_wdata[IW-1:0];
      end
   end

   for (genvar g = 0; g < NREG; g++) begin : g_reg
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            regs_q[g] <= '0;
         end else if (io_wr && hit_dat && (idx_q == IW'(g))) begin
            regs_q[g] <= io_wdata;
         end
      end
      assign regs_flat[g*DW +: DW] = regs_q[g];
   end

   assign io_rdata = (io_rd && hit_dat) ? regs_q[idx_q] : '0;

endmodule

// File: rtl/shd_seg_decode.sv
module shd_seg_decode
   import shd_pkg::*;
#(
   parameter int DW = 8,
   parameter int NREG = 16,
   parameter int AW = 20,
   parameter int LO_REG = 4,
   parameter int HI_REG = 5,
   parameter int TOP_REG = 6,
   localparam int SMALL_PER_REG = 4,
   localparam int N_SMALL = 2 * SMALL_PER_REG,
   localparam int N_BIG = 2
) (
   input  logic [NREG*DW-1:0] regs_flat,
   input  logic [AW-1:0]      mem_addr,
   input  logic               mem_we,
   output logic [1:0]         route
);

   if (AW != 20) begin : g_bad_aw
      $error("shd_seg_decode: window layout assumes a 20-bit address");
   end
   if (DW < 2 * SMALL_PER_REG) begin : g_bad_dw
      $error("shd_seg_decode: DW must hold four enable pairs");
   end
   if (TOP_REG >= NREG || HI_REG >= NREG || LO_REG >= NREG) begin : g_bad_reg
      $error("shd_seg_decode: control register out of range");
   end

   logic [N_SMALL-1:0] sm_rd, sm_wr;
   logic [N_BIG-1:0]   bg_rd, bg_wr;

   // 16 KB segments of C0000-DFFFF, ascending address order
   for (genvar s = 0; s < N_SMALL; s++) begin : g_small
      localparam int RSEL = (s < SMALL_PER_REG) ? LO_REG : HI_REG;
      localparam int PAIR = s % SMALL_PER_REG;
      assign sm_rd[s] = regs_flat[RSEL*DW + 2*PAIR];
      assign sm_wr[s] = regs_flat[RSEL*DW + 2*PAIR + 1];
   end

   // 64 KB segments E0000 and F0000
   for (genvar b = 0; b < N_BIG; b++) begin : g_big
      assign bg_rd[b] = regs_flat[TOP_REG*DW + 2*b];
      assign bg_wr[b] = regs_flat[TOP_REG*DW + 2*b + 1];
   end

   logic in_win, upper_half, rd_en, wr_en;
   logic [2:0] small_sel;
   route_e r;

   assign in_win     = &mem_addr[AW-1:AW-2];
   assign upper_half = mem_addr[AW-3];
   assign small_sel  = mem_addr[AW-4:AW-6];

   always_comb begin
      if (upper_half) begin
         rd_en = bg_rd[mem_addr[AW-4]];
         wr_en = bg_wr[mem_addr[AW-4]];
      end else begin
         rd_en = sm_rd[small_sel];
         wr_en = sm_wr[small_sel];
      end
      r = in_win ? route_of(rd_en, wr_en, mem_we) : ROUTE_INT;
   end

   assign route = r;

   logic unused_bits;
   assign unused_bits = ^{regs_flat, mem_addr[AW-7:0]};

endmodule

// File: rtl/shd_route.sv
module shd_route #(
   parameter int IO_AW = 16,
   parameter int DW = 8,
   parameter int NREG = 16,
   parameter int AW = 20,
   parameter logic [IO_AW-1:0] IDX_PORT = 16'h0022,
   parameter logic [IO_AW-1:0] DATA_PORT = 16'h0024
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             io_wr,
   input  logic             io_rd,
   input  logic [IO_AW-1:0] io_addr,
   input  logic [DW-1:0]    io_wdata,
   output logic [DW-1:0]    io_rdata,
   input  logic [AW-1:0]    mem_addr,
   input  logic             mem_we,
   output logic [1:0]       mem_route
);

   localparam int IW = $clog2(NREG);

   logic [IW-1:0]      idx_q;
   logic [NREG*DW-1:0] regs_flat;

   shd_regfile #(
      .IO_AW(IO_AW), .DW(DW), .NREG(NREG),
      .IDX_PORT(IDX_PORT), .DATA_PORT(DATA_PORT)
   ) u_rf (
      .clk(clk), .rst_n(rst_n),
      .io_wr(io_wr), .io_rd(io_rd), .io_addr(io_addr),
      .io_wdata(io_wdata), .io_rdata(io_rdata),
      .idx_q(idx_q), .regs_flat(regs_flat)
   );

   shd_seg_decode #(
      .DW(DW), .NREG(NREG), .AW(AW)
   ) u_dec (
      .regs_flat(regs_flat), .mem_addr(mem_addr),
      .mem_we(mem_we), .route(mem_route)
   );

endmodule

// File: rtl/shd_route_chk.sv
module shd_route_chk #(
   parameter int IO_AW = 16,
   parameter int DW = 8,
   parameter int NREG = 16,
   parameter int AW = 20,
   parameter logic [IO_AW-1:0] IDX_PORT = 16'h0022,
   parameter logic [IO_AW-1:0] DATA_PORT = 16'h0024,
   localparam int IW = $clog2(NREG)
) (
   input logic               clk,
   input logic               rst_n,
   input logic               io_wr,
   input logic               io_rd,
   input logic [IO_AW-1:0]   io_addr,
   input logic [DW-1:0]      io_wdata,
   input logic [DW-1:0]      io_rdata,
   input logic [AW-1:0]      mem_addr,
   input logic               mem_we,
   input logic [1:0]         mem_route,
   input logic [IW-1:0]      idx_q,
   input logic [NREG*DW-1:0] regs_flat
);

   logic [DW-1:0] rv [NREG];
   always_comb begin
      for (int i = 0; i < NREG; i++) rv[i] = regs_flat[i*DW +: DW];
   end

   logic          pend_q;
   logic [IW-1:0] pidx_q;
   logic [DW-1:0] pdat_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pend_q <= 1'b0;
         pidx_q <= '0;
         pdat_q <= '0;
      end else begin
         pend_q <= io_wr && (io_addr == DATA_PORT);
         pidx_q <= idx_q;
         pdat_q <= io_wdata;
      end
   end

   // R2
   a_r2_data_store: assert property (@(posedge clk) disable iff (!rst_n)
      pend_q |-> rv[pidx_q] == pdat_q);
   // R2
   a_r2_read_now: assert property (@(posedge clk) disable iff (!rst_n)
      (io_rd && io_addr == DATA_PORT) |-> io_rdata == rv[idx_q]);
   // R2
   a_r2_read_idle: assert property (@(posedge clk) disable iff (!rst_n)
      !(io_rd && io_addr == DATA_PORT) |-> io_rdata == '0);
   // R3
   a_r3_idx_load: assert property (@(posedge clk) disable iff (!rst_n)
      (io_wr && io_addr == IDX_PORT) |=> idx_q == $past(io_wdata[IW-1:0]));
   // R8
   a_r8_low_internal: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_addr[AW-1:AW-2] != 2'b11) |-> mem_route == 2'd0);
   // R6
   a_r6_read_no_drop: assert property (@(posedge clk) disable iff (!rst_n)
      !mem_we |-> mem_route != 2'd2);
   // R10
   a_r10_legal_code: assert property (@(posedge clk) disable iff (!rst_n)
      mem_route != 2'd3);

endmodule

bind shd_route shd_route_chk #(
   .IO_AW(IO_AW), .DW(DW), .NREG(NREG), .AW(AW),
   .IDX_PORT(IDX_PORT), .DATA_PORT(DATA_PORT)
) u_chk (
   .clk(clk), .rst_n(rst_n), .io_wr(io_wr), .io_rd(io_rd),
   .io_addr(io_addr), .io_wdata(io_wdata), .io_rdata(io_rdata),
   .mem_addr(mem_addr), .mem_we(mem_we), .mem_route(mem_route),
   .idx_q(idx_q), .regs_flat(regs_flat)
);

// File: tb/sim_shd_route.sv
`timescale 1ns/1ps
module sim_shd_route;

   localparam logic [15:0] PIDX = 16'h0022;
   localparam logic [15:0] PDAT = 16'h0024;
   localparam int NV = 20;

   // Configuration used by the vector walk:
   // reg4 = 9C: C0000 00, C4000 11, C8000 01(rd only), CC000 10(wr only)
   // reg5 = 07: D0000 11, D4000 01, D8000 00, DC000 00
   // reg6 = 09: E rd only, F wr only
   // Entry = {addr[19:0], we, expected code[1:0]}
   localparam logic [22:0] VEC [NV] = '{
      {20'h00000, 1'b0, 2'd0}, {20'hBFFFF, 1'b1, 2'd0},
      {20'hC0000, 1'b0, 2'd1}, {20'hC3FFF, 1'b1, 2'd1},
      {20'hC4000, 1'b0, 2'd0}, {20'hC7FFF, 1'b1, 2'd0},
      {20'hC8000, 1'b0, 2'd0}, {20'hCBFFF, 1'b1, 2'd2},
      {20'hCC000, 1'b0, 2'd1}, {20'hCFFFF, 1'b1, 2'd0},
      {20'hD0000, 1'b0, 2'd0}, {20'hD0000, 1'b1, 2'd0},
      {20'hD4000, 1'b0, 2'd0}, {20'hD7FFF, 1'b1, 2'd2},
      {20'hD8000, 1'b0, 2'd1}, {20'hDC000, 1'b1, 2'd1},
      {20'hE0000, 1'b0, 2'd0}, {20'hEFFFF, 1'b1, 2'd2},
      {20'hF0000, 1'b0, 2'd1}, {20'hFFFF0, 1'b1, 2'd0}
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        io_wr = 1'b0, io_rd = 1'b0;
   logic [15:0] io_addr = '0;
   logic [7:0]  io_wdata = '0;
   logic [7:0]  io_rdata;
   logic [19:0] mem_addr = '0;
   logic        mem_we = 1'b0;
   logic [1:0]  mem_route;

   int n_run = 0, n_fail = 0;

   always #2 clk = ~clk;

   shd_route u0 (
      .clk(clk), .rst_n(rst_n), .io_wr(io_wr), .io_rd(io_rd),
      .io_addr(io_addr), .io_wdata(io_wdata), .io_rdata(io_rdata),
      .mem_addr(mem_addr), .mem_we(mem_we), .mem_route(mem_route)
   );

   task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic io_write(input logic [15:0] p, input logic [7:0] d);
      @(negedge clk);
      io_addr = p; io_wdata = d; io_wr = 1'b1;
      @(negedge clk);
      io_wr = 1'b0;
   endtask

   task automatic io_read(input logic [15:0] p, output logic [7:0] v);
      @(negedge clk);
      io_addr = p; io_rd = 1'b1;
      #1 v = io_rdata;
      io_rd = 1'b0;
   endtask

   task automatic probe(input logic [19:0] a, input logic w, output logic [1:0] r);
      @(negedge clk);
      mem_addr = a; mem_we = w;
      #1 r = mem_route;
   endtask

   initial begin
      #(4 * 200000);
      n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      logic [7:0] v;
      logic [1:0] r;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1: reset state, every window region external for reads and writes
      probe(20'hC0000, 1'b0, r); check("R1 C0000 rd", 8'(r), 8'd1);
      probe(20'hDC000, 1'b1, r); check("R1 DC000 wr", 8'(r), 8'd1);
      probe(20'hE8000, 1'b1, r); check("R1 E8000 wr", 8'(r), 8'd1);
      probe(20'hF0000, 1'b0, r); check("R1 F0000 rd", 8'(r), 8'd1);
      io_read(PDAT, v); check("R1 reg0 zero", v, 8'h00);
      io_write(PIDX, 8'h06);
      io_read(PDAT, v); check("R1 reg6 zero", v, 8'h00);

      // R2, R4, R5: program the three control registers
      io_write(PIDX, 8'h04); io_write(PDAT, 8'h9C);
      io_write(PIDX, 8'h05); io_write(PDAT, 8'h07);
      io_write(PIDX, 8'h06); io_write(PDAT, 8'h09);
      io_write(PIDX, 8'h0F); io_write(PDAT, 8'hA5);
      io_write(PIDX, 8'h04);
      io_read(PDAT, v); check("R2 readback reg4", v, 8'h9C);
      io_write(PIDX, 8'h0F);
      io_read(PDAT, v); check("R2 readback reg15", v, 8'hA5);
      // R2: idle read data and read at the index port give zero
      @(negedge clk); io_addr = PDAT; #1 check("R2 no strobe rdata", io_rdata, 8'h00);
      io_read(PIDX, v); check("R2 index port read", v, 8'h00);

      // R3: upper index bits ignored, 0x15 selects reg5
      io_write(PIDX, 8'h15);
      io_read(PDAT, v); check("R3 index alias reg5", v, 8'h07);
      io_write(PIDX, 8'hF6);
      io_read(PDAT, v); check("R3 index alias reg6", v, 8'h09);

      // R4 R5 R6 R7 R8: vector walk
      for (int i = 0; i < NV; i++) begin
         probe(VEC[i][22:3], VEC[i][2], r);
         check($sformatf("R4/R5/R6/R7/R8 vec%0d addr=%h we=%0d", i, VEC[i][22:3], VEC[i][2]),
               8'(r), 8'(VEC[i][1:0]));
      end

      // R8: low memory stays internal under any write pattern
      probe(20'h0C000, 1'b1, r); check("R8 0C000 wr", 8'(r), 8'd0);
      probe(20'h8FFFF, 1'b0, r); check("R8 8FFFF rd", 8'(r), 8'd0);

      // R9: change lands exactly on the storing edge (index is 6 here)
      probe(20'hF0000, 1'b1, r); check("R9 before", 8'(r), 8'd0);
      @(negedge clk);
      io_addr = PDAT; io_wdata = 8'h00; io_wr = 1'b1;
      #1 check("R9 pre-edge unchanged", 8'(mem_route), 8'd0);
      @(negedge clk);
      io_wr = 1'b0;
      #1 check("R9 post-edge new route", 8'(mem_route), 8'd1);

      // R7: write with both enables clear is external, with rd only discarded
      io_write(PDAT, 8'h04);
      probe(20'hF8000, 1'b1, r); check("R7 F rd-only wr discard", 8'(r), 8'd2);
      probe(20'hF8000, 1'b0, r); check("R6 F rd-only rd internal", 8'(r), 8'd0);
      probe(20'hE0000, 1'b1, r); check("R7 E cleared wr external", 8'(r), 8'd1);

      // R10: no illegal code seen over a sweep of window segments
      for (int s = 0; s < 16; s++) begin
         probe(20'hC0000 + 20'(s) * 20'h4000, s[0], r);
         check($sformatf("R10 seg%0d code legal", s), 8'(r == 2'd3), 8'd0);
      end

      // R1: reset again clears configuration
      @(negedge clk); rst_n = 1'b0;
      @(negedge clk); rst_n = 1'b1;
      probe(20'hC4000, 1'b0, r); check("R1 after re-reset", 8'(r), 8'd1);

      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

endmodule